// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This block is the hazard-control logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. It looks at the register numbers held in the decode-side and execute-side stage registers, and at the destination numbers and write enables held in the two later stage registers. From these it decides where each ALU operand must come from: the register file, the ALU result waiting in the execute/memory register, or the value about to be written back from the memory/writeback register.

The block also detects an instruction that sits in decode and reads a register that the load now in execute will write. The loaded word only exists at the end of the memory stage. For that case the block raises a hold that freezes the program counter and the fetch/decode register. In the same cycle it raises a bubble that forces no-operation control into the execute stage. One cycle later the load has moved to the memory/writeback register, and the normal bypass path delivers its data. A dependency on an ALU result never holds the pipeline, because the result can be bypassed in the very next cycle.

Top module: `hz_ctrl`

## Requirements
- R1: Each operand select is a 2-bit code: 2'b00 selects the register-file value, 2'b10 the execute/memory ALU result, and 2'b01 the memory/writeback value. Code 2'b11 is never produced. With no qualifying match the code is 2'b00.
- R2: An operand select is 2'b10 when the execute/memory write enable is 1 and its destination equals that operand's execute-stage source number.
- R3: An operand select is 2'b01 when the memory/writeback write enable is 1, its destination equals the operand source, and the execute/memory stage does not also qualify.
- R4: When both later stages qualify for the same operand, the code is 2'b10 (the newer value wins).
- R5: A source number of 0 always gives code 2'b00 and never causes a hold.
- R6: A destination match from a stage whose write enable is 0 has no effect on the operand select.
- R7: When the execute stage holds a load (load flag 1) whose destination is nonzero and equals either decode-stage source, `hold_front` and `bubble_ex` are both 1.
- R8: When the execute-stage load flag is 0, `hold_front` and `bubble_ex` are 0, whatever the register numbers are (back-to-back ALU dependencies never hold).
- R9: `hold_front` and `bubble_ex` are always equal, and they do not depend on the execute-stage source numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | 5 | First source register of the instruction in the fetch/decode register (instruction bits 25:21) |
| dec_src_b | input | 5 | Second source register of the instruction in the fetch/decode register (instruction bits 20:16) |
| exe_src_a | input | 5 | First source register held in the decode/execute register |
| exe_src_b | input | 5 | Second source register held in the decode/execute register |
| exe_dst | input | 5 | Destination register held in the decode/execute register |
| exe_is_load | input | 1 | Decode/execute register holds a memory read |
| mem_dst | input | 5 | Destination register held in the execute/memory register |
| mem_wen | input | 1 | Register write enable held in the execute/memory register |
| wb_dst | input | 5 | Destination register held in the memory/writeback register |
| wb_wen | input | 1 | Register write enable held in the memory/writeback register |
| fwd_sel_a | output | 2 | Multiplexer select for ALU operand A |
| fwd_sel_b | output | 2 | Multiplexer select for ALU operand B |
| hold_front | output | 1 | Disables writes to the program counter and the fetch/decode register |
| bubble_ex | output | 1 | Forces no-operation control into the decode/execute register |

## Verification
The block has no state, so a wrong decision shows at the ports in the same evaluation as the inputs that cause it. If the priority is inverted, a select reads 2'b01 where 2'b10 is due. If a write-enable or register-0 qualifier is missing, a forward appears on an idle or zero register. If the interlock compare is wrong, the hold and bubble pair rises on ALU producers, or stays low on a real load-use pair. Random vectors over a narrow range of register numbers make coincident matches common, and directed vectors pin down each priority and qualifier case.

// File: rtl/hz_pkg.sv
// Package: shared constants for the bypass and interlock logic.
// Assumes register numbers are REG_AW bits wide and register 0 is hard-wired zero.
package hz_pkg;
    localparam int REG_AW = 5;
    localparam int SEL_W  = 2;

    localparam logic [SEL_W-1:0] SEL_RF    = 2'b00;
    localparam logic [SEL_W-1:0] SEL_MEMWB = 2'b01;
    localparam logic [SEL_W-1:0] SEL_EXMEM = 2'b10;

    // True when a producing stage writes the nonzero register a consumer reads.
    function automatic logic reg_hit(input logic [REG_AW-1:0] src,
                                     input logic [REG_AW-1:0] dst,
                                     input logic              wen);
        return wen && (src != '0) && (src == dst);
    endfunction
endpackage

// File: rtl/hz_bypass_sel.sv
// Module: hz_bypass_sel
// Chooses the source of one ALU operand. The execute/memory stage has
// priority over memory/writeback. Assumes the stage fields are stable
// register outputs and that register 0 is never a valid bypass target.
module hz_bypass_sel
    import hz_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic [AW-1:0]    src,
    input  logic [AW-1:0]    mem_dst,
    input  logic             mem_wen,
    input  logic [AW-1:0]    wb_dst,
    input  logic             wb_wen,
    output logic [SEL_W-1:0] sel
);
    logic hit_mem;
    logic hit_wb;

    // Compare the source against both producing stages.
    always_comb begin
        hit_mem = mem_wen && (src != '0) && (src == mem_dst);
        hit_wb  = wb_wen  && (src != '0) && (src == wb_dst);
    end

    // Priority pick: the newest producer wins.
    always_comb begin
        if (hit_mem)     sel = SEL_EXMEM;
        else if (hit_wb) sel = SEL_MEMWB;
        else             sel = SEL_RF;
    end

    // Checks relating the select to the stage fields.
    always_comb begin
        a_r1_legal_code: assert (sel != 2'b11);
        a_r2_exmem_qual: assert ((sel != SEL_EXMEM) || (mem_wen && src == mem_dst));
        a_r4_memwb_only_without_exmem:
            assert ((sel != SEL_MEMWB) || (wb_wen && src == wb_dst && !(mem_wen && src == mem_dst)));
        a_r5_zero_src_rf: assert ((src != '0) || (sel == SEL_RF));
    end
endmodule

// File: rtl/hz_load_interlock.sv
// Module: hz_load_interlock
// Detects a load in execute whose destination is read by the instruction
// in decode. Raises the front-end hold and the execute bubble together.
// Assumes a load always writes its destination register.
module hz_load_interlock
    import hz_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic [AW-1:0] dec_src_a,
    input  logic [AW-1:0] dec_src_b,
    input  logic [AW-1:0] exe_dst,
    input  logic          exe_is_load,
    output logic          hold_front,
    output logic          bubble_ex
);
    logic use_hit;

    // Load-use compare against both decode sources.
    always_comb begin
        use_hit = exe_is_load &&
                  (reg_hit(dec_src_a, exe_dst, 1'b1) || reg_hit(dec_src_b, exe_dst, 1'b1));
    end

    // Drive the hold and the bubble from the single detection.
    always_comb begin
        hold_front = use_hit;
        bubble_ex  = use_hit;
    end

    // Checks on the hold qualifiers.
    always_comb begin
        a_r8_hold_needs_load: assert (!hold_front || exe_is_load);
        a_r5_hold_not_on_r0: assert (!hold_front || exe_dst != '0);
        a_r7_hold_on_match:
            assert (!hold_front || dec_src_a == exe_dst || dec_src_b == exe_dst);
    end
endmodule

// File: rtl/hz_ctrl.sv
// Module: hz_ctrl (top)
// Combinational hazard control of a five-stage in-order pipeline: two
// operand bypass selects and a one-bubble load-use interlock.
// Assumes all inputs come straight from stage registers.
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int AW       = REG_AW,
    parameter int N_OPERND = 2
) (
    input  logic [AW-1:0]    dec_src_a,
    input  logic [AW-1:0]    dec_src_b,
    input  logic [AW-1:0]    exe_src_a,
    input  logic [AW-1:0]    exe_src_b,
    input  logic [AW-1:0]    exe_dst,
    input  logic             exe_is_load,
    input  logic [AW-1:0]    mem_dst,
    input  logic             mem_wen,
    input  logic [AW-1:0]    wb_dst,
    input  logic             wb_wen,
    output logic [SEL_W-1:0] fwd_sel_a,
    output logic [SEL_W-1:0] fwd_sel_b,
    output logic             hold_front,
    output logic             bubble_ex
);
    logic [AW-1:0]    src_vec [N_OPERND];
    logic [SEL_W-1:0] sel_vec [N_OPERND];

    // Gather the execute-stage sources into an indexed set.
    always_comb begin
        src_vec[0] = exe_src_a;
        src_vec[1] = exe_src_b;
    end

    // One bypass selector per ALU operand.
    for (genvar g = 0; g < N_OPERND; g++) begin : g_opnd
        hz_bypass_sel #(.AW(AW)) u_sel (
            .src     (src_vec[g]),
            .mem_dst (mem_dst),
            .mem_wen (mem_wen),
            .wb_dst  (wb_dst),
            .wb_wen  (wb_wen),
            .sel     (sel_vec[g])
        );
    end

    // Drive the operand selects out.
    always_comb begin
        fwd_sel_a = sel_vec[0];
        fwd_sel_b = sel_vec[1];
    end

    hz_load_interlock #(.AW(AW)) u_ilk (
        .dec_src_a   (dec_src_a),
        .dec_src_b   (dec_src_b),
        .exe_dst     (exe_dst),
        .exe_is_load (exe_is_load),
        .hold_front  (hold_front),
        .bubble_ex   (bubble_ex)
    );

    // Top-level checks across the two sub-blocks.
    always_comb begin
        a_r9_hold_eq_bubble: assert (hold_front == bubble_ex);
        a_r6_no_fwd_when_idle: assert ((mem_wen || wb_wen) || (fwd_sel_a == SEL_RF && fwd_sel_b == SEL_RF));
    end
endmodule

// File: tb/hz_ctrl_bench.sv
// Bench for hz_ctrl: directed corner cases, then seeded random vectors,
// each compared with models written from the requirements.
module hz_ctrl_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [4:0] dec_src_a, dec_src_b, exe_src_a, exe_src_b, exe_dst, mem_dst, wb_dst;
    logic       exe_is_load, mem_wen, wb_wen;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic       hold_front, bubble_ex;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    hz_ctrl u_hz_ctrl (.*);

    // Expected select from the requirement text.
    function automatic logic [1:0] exp_sel(input logic [4:0] s);
        if (s == 0) return 2'b00;
        if (mem_wen && mem_dst == s) return 2'b10;
        if (wb_wen && wb_dst == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string sel_tag(input logic [4:0] s);
        if (s == 0) return "R5";
        if (mem_wen && mem_dst == s && wb_wen && wb_dst == s) return "R4";
        if (mem_wen && mem_dst == s) return "R2";
        if (wb_wen && wb_dst == s) return "R3";
        if ((mem_dst == s) || (wb_dst == s)) return "R6";
        return "R1";
    endfunction

    function automatic logic exp_hold();
        return exe_is_load && exe_dst != 0 && (exe_dst == dec_src_a || exe_dst == dec_src_b);
    endfunction

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one vector away from the edge, then compare all outputs.
    task automatic apply(input logic [4:0] da, db, ea, eb, ed, input logic ld,
                         input logic [4:0] md, input logic mw, input logic [4:0] wd, input logic ww);
        @(negedge clk);
        dec_src_a = da; dec_src_b = db; exe_src_a = ea; exe_src_b = eb;
        exe_dst = ed; exe_is_load = ld; mem_dst = md; mem_wen = mw; wb_dst = wd; wb_wen = ww;
        #2;
        chk(sel_tag(ea), fwd_sel_a, exp_sel(ea));
        chk(sel_tag(eb), fwd_sel_b, exp_sel(eb));
        chk(ld ? "R7" : "R8", {1'b0, hold_front}, {1'b0, exp_hold()});
        chk("R9", {1'b0, bubble_ex}, {1'b0, hold_front});
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        // Quiet state: all fields zero (R1).
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2: EX/MEM bypass on A; R3: MEM/WB bypass on B.
        apply(1, 2, 3, 4, 9, 0, 3, 1, 4, 1);
        // R4: both stages write r7.
        apply(1, 2, 7, 7, 9, 0, 7, 1, 7, 1);
        // R5: r0 matches everywhere, load of r0.
        apply(0, 0, 0, 0, 0, 1, 0, 1, 0, 1);
        // R6: matches with write enables low.
        apply(1, 2, 5, 6, 9, 0, 5, 0, 6, 0);
        // R6: EX/MEM disabled, MEM/WB enabled on same register -> 01.
        apply(1, 2, 5, 5, 9, 0, 5, 0, 5, 1);
        // R7: load-use on A, then on B.
        apply(8, 2, 1, 1, 8, 1, 0, 0, 0, 0);
        apply(3, 8, 1, 1, 8, 1, 0, 0, 0, 0);
        // R8: ALU producer with same match, no hold.
        apply(8, 8, 1, 1, 8, 0, 0, 0, 0, 0);
        // R9: execute sources equal load dest but decode does not.
        apply(3, 4, 8, 8, 8, 1, 0, 0, 0, 0);
        // Random vectors over a narrow register range.
        for (int i = 0; i < 3000; i++) begin
            apply($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                  $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom),
                  $urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3), 1'($urandom));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule